// File: doc/BRIEF.md
# Multi-Format Serial Audio Transmitter

This block takes one stereo pair of 24-bit two's-complement PCM samples at a time and sends them as a serial stream on a three-wire audio link: a bit clock, a word (channel) clock and a data line. The sender loads a new pair with a one-cycle strobe. When each half-frame begins, the block takes that channel's word from the held pair and shifts it out MSB first. It moves the data line only after a falling bit-clock edge, so the line is settled for the receiver at the rising edge.

A two-bit format code picks the placement of the word inside each half-frame: left-justified, I2S, right-justified with 24 bits, or right-justified with the 20 most significant bits. A two-bit mode code picks who owns the link clocks. In slave mode the bit and word clocks come in from outside, synchronous to the system clock. In the three master modes the block divides the system clock down to a 64-bit-clock frame. Everything runs on the single system clock. The data line is a register, and in master mode the two link clocks are registers too.

Top module: `audio_ser_tx`

## Requirements
- R1: Format code 00 is left-justified: the word MSB is in slot 0 of a half-frame (the first bit-clock period after the word clock changes), the lower bits follow one per slot, every slot after the LSB is 0, and a high word clock marks the left channel.
- R2: Format code 01 is I2S: slot 0 carries 0, the MSB is in slot 1, every slot after the LSB is 0, and a low word clock marks the left channel.
- R3: Format code 10 is right-justified 24-bit: the word LSB is in the last slot of the half-frame, the MSB is 24 slots before the end, leading slots carry 0, and a high word clock marks the left channel.
- R4: Format code 11 is right-justified 20-bit: word bits 23 down to 4 fill the last 20 slots of the half-frame, leading slots carry 0, and a high word clock marks the left channel.
- R5: In master mode the bit clock period is 8, 6 or 4 system clocks for mode codes 01, 10 and 11 (512, 384 and 256 times the sample rate). The bit clock is low for the first half of each period.
- R6: In master mode every half-frame lasts 32 bit-clock periods (64 per frame), and the word clock changes only on a system-clock edge where the bit clock falls.
- R7: The data line changes only on the system-clock edge that follows a falling bit-clock edge, so it never changes while the bit clock stays high.
- R8: Mode code 00 is slave mode. The bit and word clock inputs, which must be synchronous to the system clock, time the link, and the bit and word clock outputs are held at 0.
- R9: In slave mode frames of 64 or 48 bit clocks are accepted. The right-justified placement follows the length of the half-frame that just ended.
- R10: A strobe on in_valid captures both samples. Each channel takes its word at the start of its own half-frame, so a strobe in the middle of a half-frame does not change the bits of that half-frame.
- R11: While rst_n is low (sampled at the rising clock edge), the data line and both clock outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all logic samples on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| fmt_sel | input | 2 | Data placement code (see R1 to R4) |
| mode_sel | input | 2 | Clock ownership and divide code (see R5, R8) |
| in_valid | input | 1 | One-cycle strobe that captures both samples |
| in_left | input | 24 | Left-channel sample, two's complement |
| in_right | input | 24 | Right-channel sample, two's complement |
| bck_in | input | 1 | Bit clock from outside, used in slave mode |
| lrck_in | input | 1 | Word clock from outside, used in slave mode |
| bck_out | output | 1 | Generated bit clock in master mode, 0 in slave mode |
| lrck_out | output | 1 | Generated word clock in master mode, 0 in slave mode |
| dout | output | 1 | Serial data, MSB first |

## Verification
The bench decodes the data line at each rising bit-clock edge, slot by slot, and compares every half-frame with a word built from the requirements. This catches a design that swaps channel polarity between I2S and the other formats, leaves out the I2S one-slot delay, or places a right-justified word one slot off its end. In slave mode, 48-clock frames are the hard case: a design that assumes 32 slots per half-frame puts right-justified data far too late. A sample strobe in the middle of a half-frame shows whether the design latches each channel at its own half-frame start; a design that shifts straight from the input registers corrupts the half-frame in progress. Each master divide ratio is measured as a bit-clock period, which exposes a swapped mode code.

// File: rtl/ast_pkg.sv
package ast_pkg;
   typedef enum logic [1:0] {
      FMT_LEFT_J   = 2'b00,
      FMT_I2S      = 2'b01,
      FMT_RIGHT_J  = 2'b10,
      FMT_RIGHT_JS = 2'b11
   } fmt_e;

   typedef enum logic [1:0] {
      MODE_SLAVE = 2'b00,
      MODE_M512  = 2'b01,
      MODE_M384  = 2'b10,
      MODE_M256  = 2'b11
   } mode_e;
endpackage

// File: rtl/ast_clkgen.sv
module ast_clkgen #(
   parameter int DIV_W     = 4,
   parameter int FRAME_BCK = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [DIV_W-1:0] div_ratio,
   input  logic             left_hi,
   output logic             bck_o,
   output logic             lrck_o
);
   localparam int BIT_W = $clog2(FRAME_BCK);

   logic [DIV_W-1:0] cnt_q, cnt_nxt, half_div;
   logic [BIT_W-1:0] bit_q, bit_nxt;
   logic             fall_nxt;

   always_comb begin
      half_div = div_ratio >> 1;
      cnt_nxt  = (cnt_q >= div_ratio - 1'b1) ? '0 : cnt_q + 1'b1;
      fall_nxt = (cnt_nxt == '0);
      bit_nxt  = fall_nxt ? bit_q + 1'b1 : bit_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || !en) begin
         cnt_q  <= '0;
         bit_q  <= '1;
         bck_o  <= 1'b0;
         lrck_o <= 1'b0;
      end else begin
         cnt_q <= cnt_nxt;
         bit_q <= bit_nxt;
         bck_o <= (cnt_nxt >= half_div);
         if (fall_nxt)
            lrck_o <= bit_nxt[BIT_W-1] ? ~left_hi : left_hi;
      end
   end
endmodule

// File: rtl/ast_slot_track.sv
module ast_slot_track #(
   parameter int SLOT_W   = 6,
   parameter int HALF_DEF = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bck_line,
   input  logic              lrck_line,
   output logic              fall_ev,
   output logic              new_half,
   output logic [SLOT_W-1:0] slot,
   output logic [SLOT_W-1:0] half_len
);
   logic              bck_prev_q, lr_last_q, started_q;
   logic [SLOT_W-1:0] slot_q, len_q;

   always_comb begin
      fall_ev  = bck_prev_q & ~bck_line;
      new_half = fall_ev & (~started_q | (lrck_line != lr_last_q));
      slot     = new_half ? '0 : slot_q + 1'b1;
      half_len = (new_half && started_q) ? slot_q + 1'b1 : len_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bck_prev_q <= 1'b0;
         lr_last_q  <= 1'b0;
         started_q  <= 1'b0;
         slot_q     <= '0;
         len_q      <= SLOT_W'(HALF_DEF);
      end else begin
         bck_prev_q <= bck_line;
         if (fall_ev) begin
            slot_q    <= slot;
            lr_last_q <= lrck_line;
            started_q <= 1'b1;
            len_q     <= half_len;
         end
      end
   end
endmodule

// File: rtl/ast_shifter.sv
module ast_shifter import ast_pkg::*; #(
   parameter int DATA_W  = 24,
   parameter int SHORT_W = 20,
   parameter int SLOT_W  = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  fmt_e              fmt,
   input  logic              fall_ev,
   input  logic              new_half,
   input  logic [SLOT_W-1:0] slot,
   input  logic [SLOT_W-1:0] half_len,
   input  logic              lr_level,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_left,
   input  logic [DATA_W-1:0] in_right,
   output logic              dout
);
   localparam logic [SLOT_W-1:0] WID_FULL  = SLOT_W'(DATA_W);
   localparam logic [SLOT_W-1:0] WID_SHORT = SLOT_W'(SHORT_W);

   generate
      for (genvar c = 0; c < 2; c++) begin : g_chan
         logic [DATA_W-1:0] held_q;
         always_ff @(posedge clk) begin
            if (!rst_n)
               held_q <= '0;
            else if (in_valid)
               held_q <= (c == 0) ? in_left : in_right;
         end
      end
   endgenerate

   logic [DATA_W-1:0] word_q, word_sel, shifted;
   logic [SLOT_W-1:0] wid, start, pos;
   logic              is_left, in_win, bit_nxt;

   always_comb begin
      is_left  = (fmt == FMT_I2S) ? ~lr_level : lr_level;
      word_sel = new_half ? (is_left ? g_chan[0].held_q : g_chan[1].held_q) : word_q;
      wid      = (fmt == FMT_RIGHT_JS) ? WID_SHORT : WID_FULL;
      case (fmt)
         FMT_LEFT_J: start = '0;
         FMT_I2S:    start = SLOT_W'(1);
         default:    start = (half_len > wid) ? half_len - wid : '0;
      endcase
      pos     = slot - start;
      in_win  = (slot >= start) && (pos < wid);
      shifted = word_sel << pos;
      bit_nxt = in_win & shifted[DATA_W-1];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         word_q <= '0;
         dout   <= 1'b0;
      end else if (fall_ev) begin
         word_q <= word_sel;
         dout   <= bit_nxt;
      end
   end
endmodule

// File: rtl/audio_ser_tx.sv
module audio_ser_tx import ast_pkg::*; #(
   parameter int DATA_W    = 24,
   parameter int SHORT_W   = 20,
   parameter int FRAME_BCK = 64,
   parameter int RATIO_HI  = 512,
   parameter int RATIO_MID = 384,
   parameter int RATIO_LO  = 256,
   parameter int DIV_W     = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        fmt_sel,
   input  logic [1:0]        mode_sel,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_left,
   input  logic [DATA_W-1:0] in_right,
   input  logic              bck_in,
   input  logic              lrck_in,
   output logic              bck_out,
   output logic              lrck_out,
   output logic              dout
);
   localparam int SLOT_W = $clog2(FRAME_BCK);
   localparam int HALF   = FRAME_BCK / 2;
   localparam logic [DIV_W-1:0] DIV_HI  = DIV_W'(RATIO_HI / FRAME_BCK);
   localparam logic [DIV_W-1:0] DIV_MID = DIV_W'(RATIO_MID / FRAME_BCK);
   localparam logic [DIV_W-1:0] DIV_LO  = DIV_W'(RATIO_LO / FRAME_BCK);

   generate
      if (SHORT_W > DATA_W || SHORT_W < 1) begin : g_bad_short
         $error("SHORT_W must lie in 1..DATA_W");
      end
      if (DATA_W > HALF) begin : g_bad_data
         $error("DATA_W must fit in one half-frame");
      end
      if ((FRAME_BCK & (FRAME_BCK - 1)) != 0) begin : g_bad_frame
         $error("FRAME_BCK must be a power of two");
      end
      if ((RATIO_HI % (2 * FRAME_BCK)) != 0 || (RATIO_MID % (2 * FRAME_BCK)) != 0 ||
          (RATIO_LO % (2 * FRAME_BCK)) != 0) begin : g_bad_ratio
         $error("each ratio must give an even divide of the frame");
      end
      if ((RATIO_HI / FRAME_BCK) >= (1 << DIV_W)) begin : g_bad_div
         $error("DIV_W too narrow for the largest divide");
      end
   endgenerate

   fmt_e              fmt;
   mode_e             mode;
   logic              master;
   logic [DIV_W-1:0]  div_ratio;
   logic              gen_bck, gen_lrck;
   logic              bck_line, lrck_line;
   logic              fall_ev, new_half;
   logic [SLOT_W-1:0] slot, half_len;

   always_comb begin
      fmt    = fmt_e'(fmt_sel);
      mode   = mode_e'(mode_sel);
      master = (mode != MODE_SLAVE);
      case (mode)
         MODE_M512: div_ratio = DIV_HI;
         MODE_M384: div_ratio = DIV_MID;
         default:   div_ratio = DIV_LO;
      endcase
      bck_line  = master ? gen_bck  : bck_in;
      lrck_line = master ? gen_lrck : lrck_in;
   end

   ast_clkgen #(.DIV_W(DIV_W), .FRAME_BCK(FRAME_BCK)) clkgen_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (master),
      .div_ratio (div_ratio),
      .left_hi   (fmt != FMT_I2S),
      .bck_o     (gen_bck),
      .lrck_o    (gen_lrck)
   );

   ast_slot_track #(.SLOT_W(SLOT_W), .HALF_DEF(HALF)) track_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .bck_line  (bck_line),
      .lrck_line (lrck_line),
      .fall_ev   (fall_ev),
      .new_half  (new_half),
      .slot      (slot),
      .half_len  (half_len)
   );

   ast_shifter #(.DATA_W(DATA_W), .SHORT_W(SHORT_W), .SLOT_W(SLOT_W)) shifter_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .fmt      (fmt),
      .fall_ev  (fall_ev),
      .new_half (new_half),
      .slot     (slot),
      .half_len (half_len),
      .lr_level (lrck_line),
      .in_valid (in_valid),
      .in_left  (in_left),
      .in_right (in_right),
      .dout     (dout)
   );

   assign bck_out  = gen_bck;
   assign lrck_out = gen_lrck;
endmodule

// File: rtl/audio_ser_tx_chk.sv
module audio_ser_tx_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [1:0] mode_sel,
   input logic       bck_in,
   input logic       bck_out,
   input logic       lrck_out,
   input logic       dout
);
   logic       master, line_b, bck_d, seen_q, rise_now;
   logic [3:0] per_cnt_q, per_exp;

   always_comb begin
      master   = (mode_sel != 2'b00);
      line_b   = master ? bck_out : bck_in;
      rise_now = bck_out & ~bck_d;
      case (mode_sel)
         2'b01:   per_exp = 4'd8;
         2'b10:   per_exp = 4'd6;
         default: per_exp = 4'd4;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bck_d     <= 1'b0;
         seen_q    <= 1'b0;
         per_cnt_q <= '0;
      end else begin
         bck_d <= bck_out;
         if (rise_now) begin
            per_cnt_q <= 4'd1;
            seen_q    <= 1'b1;
         end else if (per_cnt_q != 4'hF) begin
            per_cnt_q <= per_cnt_q + 4'd1;
         end
      end
   end

   // R5
   bck_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (master && rise_now && seen_q) |-> (per_cnt_q == per_exp));

   // R6
   lrck_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (master && $past(master) && (lrck_out != $past(lrck_out))) |->
      (!bck_out && $past(bck_out)));

   // R7
   dout_hold_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_sel == $past(mode_sel) && line_b && $past(line_b)) |-> $stable(dout));

   // R8
   slave_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!master && $past(mode_sel) == 2'b00) |-> (!bck_out && !lrck_out));
endmodule

bind audio_ser_tx audio_ser_tx_chk chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .mode_sel (mode_sel),
   .bck_in   (bck_in),
   .bck_out  (bck_out),
   .lrck_out (lrck_out),
   .dout     (dout)
);

// File: tb/audio_ser_tx_tb_top.sv
module audio_ser_tx_tb_top;
   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  fmt_sel = 2'b00;
   logic [1:0]  mode_sel = 2'b11;
   logic        in_valid = 1'b0;
   logic [23:0] in_left = '0;
   logic [23:0] in_right = '0;
   logic        bck_in = 1'b0;
   logic        lrck_in = 1'b0;
   logic        bck_out, lrck_out, dout;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #(CLK_P / 2) clk = ~clk;

   audio_ser_tx dut_i (
      .clk(clk), .rst_n(rst_n), .fmt_sel(fmt_sel), .mode_sel(mode_sel),
      .in_valid(in_valid), .in_left(in_left), .in_right(in_right),
      .bck_in(bck_in), .lrck_in(lrck_in),
      .bck_out(bck_out), .lrck_out(lrck_out), .dout(dout)
   );

   // external clock source for slave mode: 4 system clocks per bit clock
   bit sl_on = 1'b0;
   int sl_bpf = 64;
   int sl_ph = 0;
   int sl_bit = 0;
   always @(negedge clk) begin
      if (!sl_on) begin
         bck_in  <= 1'b0;
         lrck_in <= 1'b0;
         sl_ph   <= 0;
         sl_bit  <= sl_bpf - 1;
      end else begin
         int nxt;
         nxt = (sl_ph + 1) % 4;
         sl_ph  <= nxt;
         bck_in <= (nxt >= 2);
         if (nxt == 0) begin
            int nb;
            nb = (sl_bit + 1) % sl_bpf;
            sl_bit  <= nb;
            lrck_in <= (nb < sl_bpf / 2);
         end
      end
   end

   // receiver model: sample data at each rising bit-clock edge
   logic [63:0] cap [2];
   int          caplen [2];
   int          halves = 0;
   int          bck_per = 0;
   logic [63:0] acc = '0;
   int          m_slot = 0;
   int          m_since = 0;
   logic        m_prev_b = 1'b0;
   logic        m_last_l = 1'b0;
   bit          m_have = 1'b0;
   always @(negedge clk) begin
      logic lb, ll;
      lb = (mode_sel == 2'b00) ? bck_in : bck_out;
      ll = (mode_sel == 2'b00) ? lrck_in : lrck_out;
      if (!rst_n) begin
         m_prev_b = 1'b0;
         m_have   = 1'b0;
         m_slot   = 0;
         m_since  = 0;
         acc      = '0;
      end else begin
         m_since++;
         if (lb && !m_prev_b) begin
            bck_per = m_since;
            m_since = 0;
            if (m_have && ll != m_last_l) begin
               cap[m_last_l]    = acc;
               caplen[m_last_l] = m_slot;
               halves++;
               acc    = '0;
               m_slot = 0;
            end
            m_have = 1'b1;
            if (m_slot < 64) acc[m_slot] = dout;
            m_slot++;
            m_last_l = ll;
         end
         m_prev_b = lb;
      end
   end

   function automatic logic [63:0] exp_half(input logic [1:0] f, input logic [23:0] w,
                                            input int len);
      logic [63:0] r;
      int st, wd;
      r  = '0;
      wd = (f == 2'b11) ? 20 : 24;
      st = (f == 2'b00) ? 0 : (f == 2'b01) ? 1 : len - wd;
      for (int k = 0; k < len; k++) begin
         int p;
         p = k - st;
         if (p >= 0 && p < wd) r[k] = w[23 - p];
      end
      return r;
   endfunction

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] expv);
      checks++;
      if (act !== expv) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, expv);
      end
   endtask

   task automatic setup(input logic [1:0] f, input logic [1:0] m, input int bpf);
      @(negedge clk);
      rst_n    = 1'b0;
      sl_on    = 1'b0;
      fmt_sel  = f;
      mode_sel = m;
      sl_bpf   = bpf;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      sl_on = (m == 2'b00);
   endtask

   task automatic load(input logic [23:0] l, input logic [23:0] r);
      @(negedge clk);
      in_left  = l;
      in_right = r;
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic wait_halves(input int n);
      int h0;
      h0 = halves;
      while (halves < h0 + n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic t_reset();
      rst_n    = 1'b0;
      mode_sel = 2'b11;
      repeat (3) @(negedge clk);
      chk("R11 dout in reset", {63'd0, dout}, 64'd0);
      chk("R11 bck_out in reset", {63'd0, bck_out}, 64'd0);
      chk("R11 lrck_out in reset", {63'd0, lrck_out}, 64'd0);
   endtask

   task automatic t_master_lj();
      setup(2'b00, 2'b11, 64);
      load(24'hA5C3E1, 24'h1234FF);
      wait_halves(5);
      chk("R5 bck period mode 11", 64'(bck_per), 64'd4);
      chk("R6 half-frame length", 64'(caplen[1]), 64'd32);
      chk("R1 left-justified left (lrck high)", cap[1], exp_half(2'b00, 24'hA5C3E1, 32));
      chk("R1 left-justified right", cap[0], exp_half(2'b00, 24'h1234FF, 32));
   endtask

   task automatic t_master_i2s();
      setup(2'b01, 2'b10, 64);
      load(24'h800001, 24'h7FFFFE);
      wait_halves(5);
      chk("R5 bck period mode 10", 64'(bck_per), 64'd6);
      chk("R2 i2s left (lrck low)", cap[0], exp_half(2'b01, 24'h800001, 32));
      chk("R2 i2s right", cap[1], exp_half(2'b01, 24'h7FFFFE, 32));
   endtask

   task automatic t_master_rj24();
      setup(2'b10, 2'b01, 64);
      load(24'hC00003, 24'h5A5A5B);
      wait_halves(5);
      chk("R5 bck period mode 01", 64'(bck_per), 64'd8);
      chk("R3 right-justified 24 left", cap[1], exp_half(2'b10, 24'hC00003, 32));
      chk("R3 right-justified 24 right", cap[0], exp_half(2'b10, 24'h5A5A5B, 32));
   endtask

   task automatic t_master_rj20();
      setup(2'b11, 2'b11, 64);
      load(24'hFEDCBA, 24'h0F0F1F);
      wait_halves(5);
      chk("R4 right-justified 20 left", cap[1], exp_half(2'b11, 24'hFEDCBA, 32));
      chk("R4 right-justified 20 right", cap[0], exp_half(2'b11, 24'h0F0F1F, 32));
   endtask

   task automatic t_slave();
      setup(2'b10, 2'b00, 64);
      load(24'h9ABCDE, 24'h135799);
      wait_halves(6);
      chk("R8 bck_out held low in slave", {63'd0, bck_out}, 64'd0);
      chk("R8 lrck_out held low in slave", {63'd0, lrck_out}, 64'd0);
      chk("R9 slave 64 rj24 left", cap[1], exp_half(2'b10, 24'h9ABCDE, 32));
      setup(2'b10, 2'b00, 48);
      load(24'h9ABCDE, 24'h135799);
      wait_halves(6);
      chk("R9 slave 48 half length", 64'(caplen[0]), 64'd24);
      chk("R9 slave 48 rj24 right", cap[0], exp_half(2'b10, 24'h135799, 24));
      setup(2'b11, 2'b00, 48);
      load(24'h876543, 24'h2468AC);
      wait_halves(6);
      chk("R9 slave 48 rj20 left", cap[1], exp_half(2'b11, 24'h876543, 24));
      setup(2'b00, 2'b00, 48);
      load(24'h3C3C3D, 24'hE1E1E0);
      wait_halves(6);
      chk("R9 slave 48 left-justified right", cap[0], exp_half(2'b00, 24'hE1E1E0, 24));
   endtask

   task automatic t_latch();
      int h;
      setup(2'b00, 2'b11, 64);
      load(24'h111111, 24'h222222);
      wait_halves(4);
      @(posedge lrck_out);
      repeat (9) @(negedge clk);
      load(24'hABCDEF, 24'h765432);
      @(negedge lrck_out);
      h = halves;
      while (halves <= h) @(posedge clk);
      @(negedge clk);
      chk("R10 left half keeps old word", cap[1], exp_half(2'b00, 24'h111111, 32));
      while (halves <= h + 1) @(posedge clk);
      @(negedge clk);
      chk("R10 next right half takes new word", cap[0], exp_half(2'b00, 24'h765432, 32));
      while (halves <= h + 2) @(posedge clk);
      @(negedge clk);
      chk("R10 next left half takes new word", cap[1], exp_half(2'b00, 24'hABCDEF, 32));
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete actual=hung expected=done");
      finish_run();
   end

   initial begin
      t_reset();
      t_master_lj();
      t_master_i2s();
      t_master_rj24();
      t_master_rj20();
      t_slave();
      t_latch();
      finish_run();
   end
endmodule